// File: doc/BRIEF.md
# Synchronous Burst Read Timing Sequencer

This block paces synchronous burst reads from an external NOR-style memory. It makes a memory clock from the system clock as a one-cycle enable pulse. The pulse marks each rising edge of the memory clock, and its period is set by a programmable divide field. After a request is accepted, the block counts a programmable first-data latency in memory clock periods. It then captures the read data bus once per memory clock period until the requested number of beats has been delivered.

When the transaction addressed a memory with multiplexed address and data, the block adds a turnaround phase of a programmable number of system cycles. During that phase no new transaction may drive the bus. The timing fields sit in a 32-bit configuration word that has a simple write port. A transaction copies the fields when it is accepted, so a write made during a burst takes effect at the next transaction.

Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole transaction, so a request held while the block is busy waits and is not lost. The data output is a stream with no back-pressure, because the memory cannot be stalled once the burst has started. The consumer must take every beat on the cycle `dout_valid` is high.

Top module: `sbm_timing_seq`

## Requirements
- R1: Reset leaves the configuration word at 0x0FFFFFFF, with every timing field at its maximum. After reset `busy` is low, `req_ready` and `bus_drive_ok` are high, and `mclk_en` and `dout_valid` are low.
- R2: Bits 23:20 of the configuration word hold the divide field D. While a burst runs, `mclk_en` pulses for one cycle every D+1 system cycles. The first pulse comes in the cycle right after acceptance (cycle 0). `mclk_en` is never high while the block is idle.
- R3: A divide field of 0 acts as divide-by-2, and two consecutive cycles never both carry `mclk_en`.
- R4: Bits 27:24 hold the latency field L. The first beat is captured at memory clock edge number L+2, counting from edge 0. With period P, that is the system cycle (L+2)·P.
- R5: A request with length field N returns exactly N+1 beats, one per memory clock edge at consecutive edges. Each beat is the `rd_data` value present in its edge cycle, and it appears on `dout_data` with `dout_valid` high in the following cycle.
- R6: When `req_muxed` was low, `busy` falls and `bus_drive_ok` and `req_ready` rise in the cycle after the last `dout_valid`.
- R7: Bits 19:16 hold the turnaround field T. When `req_muxed` was high, `busy` stays high for T+1 further cycles after the cycle of the last `dout_valid`.
- R8: A configuration write while busy does not change the running transaction. The next accepted transaction uses the new values.
- R9: `req_ready` is low while busy. A request held during that time is not accepted and does not disturb the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_len | input | LEN_W | Beats in the burst minus one |
| req_muxed | input | 1 | Target memory multiplexes address and data |
| rd_data | input | DATA_W | Memory read data bus |
| mclk_en | output | 1 | One-cycle pulse at each memory clock rising edge |
| dout_valid | output | 1 | Captured beat valid |
| dout_data | output | DATA_W | Captured beat |
| busy | output | 1 | Transaction or turnaround in progress |
| bus_drive_ok | output | 1 | Bus may be driven by the next transaction |

## Verification
The assertions check these rules on every cycle:
- no memory clock edge occurs while idle, and no two edges fall on adjacent cycles;
- the divider phase stays below its limit;
- every beat follows an edge;
- the latched timing stays fixed while busy;
- a turnaround phase happens only for multiplexed memories and never counts past its field.

The bench's sweeps over divide, latency, length, turnaround and memory type check the exact cycle of every edge, beat and release, and the data values captured. Those scenarios also show that a configuration write during a burst is deferred to the next transaction and that a held request is not accepted.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int FLD_W    = 4;
  localparam int LAT_LSB  = 24;
  localparam int DIV_LSB  = 20;
  localparam int TURN_LSB = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_TURN  = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic [FLD_W-1:0] lat;
    logic [FLD_W-1:0] div;
    logic [FLD_W-1:0] turn;
  } timing_t;
endpackage

// File: rtl/sbm_cfg_reg.sv
module sbm_cfg_reg
  import sbm_pkg::*;
#(
  parameter logic [31:0] RST_VAL = 32'h0FFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [31:0]   wdata,
  output timing_t       fields
);
  localparam timing_t RST_FIELDS = '{
    lat:  RST_VAL[LAT_LSB  +: FLD_W],
    div:  RST_VAL[DIV_LSB  +: FLD_W],
    turn: RST_VAL[TURN_LSB +: FLD_W]
  };

  timing_t fld_q;

  // Bits outside the three timing fields are accepted and dropped.
  logic unused_bits;
  assign unused_bits = ^{wdata[31:28], wdata[15:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= RST_FIELDS;
    end else if (we) begin
      fld_q.lat  <= wdata[LAT_LSB  +: FLD_W];
      fld_q.div  <= wdata[DIV_LSB  +: FLD_W];
      fld_q.turn <= wdata[TURN_LSB +: FLD_W];
    end
  end

  assign fields = fld_q;
endmodule

// File: rtl/sbm_mclk_gen.sv
module sbm_mclk_gen
  import sbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [FLD_W-1:0] div,
  output logic             mclk_en
);
  logic [FLD_W-1:0] phase;
  logic [FLD_W-1:0] lim;

  // Reserved divide value 0 behaves as divide-by-2.
  assign lim = (div == '0) ? FLD_W'(1) : div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart) begin
      phase <= '0;
    end else if (run) begin
      phase <= (phase == lim) ? '0 : phase + FLD_W'(1);
    end
  end

  assign mclk_en = run && (phase == '0);

  a_r3_no_adjacent_edges: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_en |=> !mclk_en);

  a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (phase <= lim));
endmodule

// File: rtl/sbm_burst_ctrl.sv
module sbm_burst_ctrl
  import sbm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_muxed,
  input  timing_t           cfg,
  input  logic              mclk_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic              start,
  output logic              run,
  output logic [FLD_W-1:0]  act_div,
  output logic              dout_valid,
  output logic [DATA_W-1:0] dout_data,
  output logic              busy,
  output logic              bus_drive_ok
);
  localparam int ECNT_W = FLD_W + 1;

  seq_state_t        state;
  timing_t           act;
  logic [LEN_W-1:0]  act_len;
  logic              act_mux;
  logic [ECNT_W-1:0] ecnt;
  logic [ECNT_W-1:0] first_edge;
  logic [LEN_W-1:0]  bcnt;
  logic [FLD_W-1:0]  tcnt;
  logic              dv_q;
  logic [DATA_W-1:0] dd_q;

  assign req_ready    = (state == ST_IDLE);
  assign start        = req_valid && req_ready;
  assign run          = (state == ST_RUN);
  assign busy         = (state != ST_IDLE);
  assign bus_drive_ok = (state == ST_IDLE);
  assign act_div      = act.div;
  assign first_edge   = {1'b0, act.lat} + ECNT_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      act     <= '0;
      act_len <= '0;
      act_mux <= 1'b0;
      ecnt    <= '0;
      bcnt    <= '0;
      tcnt    <= '0;
      dv_q    <= 1'b0;
      dd_q    <= '0;
    end else begin
      dv_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            act     <= cfg;
            act_len <= req_len;
            act_mux <= req_muxed;
            ecnt    <= '0;
            bcnt    <= '0;
          end
        end
        ST_RUN: begin
          if (mclk_en) begin
            if (ecnt >= first_edge) begin
              dv_q <= 1'b1;
              dd_q <= rd_data;
              if (bcnt == act_len) state <= ST_DRAIN;
              else                 bcnt  <= bcnt + LEN_W'(1);
            end else begin
              ecnt <= ecnt + ECNT_W'(1);
            end
          end
        end
        ST_DRAIN: begin
          if (act_mux) begin
            state <= ST_TURN;
            tcnt  <= act.turn;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_TURN: begin
          if (tcnt == '0) state <= ST_IDLE;
          else            tcnt  <= tcnt - FLD_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dout_valid = dv_q;
  assign dout_data  = dd_q;

  a_r5_beat_follows_edge: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $past(mclk_en));

  a_r8_timing_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(act) && $stable(act_len) && $stable(act_mux)));

  a_r7_turn_only_muxed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TURN) |-> (act_mux && tcnt <= act.turn));

  a_r6_release_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !act_mux) |-> $past(dout_valid));
endmodule

// File: rtl/sbm_timing_seq.sv
module sbm_timing_seq
  import sbm_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter int          LEN_W   = 4,
  parameter logic [31:0] CFG_RST = 32'h0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_muxed,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mclk_en,
  output logic              dout_valid,
  output logic [DATA_W-1:0] dout_data,
  output logic              busy,
  output logic              bus_drive_ok
);
  timing_t          cfg_fields;
  logic             start;
  logic             run;
  logic [FLD_W-1:0] act_div;

  sbm_cfg_reg #(.RST_VAL(CFG_RST)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .fields (cfg_fields)
  );

  sbm_mclk_gen u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start),
    .run     (run),
    .div     (act_div),
    .mclk_en (mclk_en)
  );

  sbm_burst_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_len      (req_len),
    .req_muxed    (req_muxed),
    .cfg          (cfg_fields),
    .mclk_en      (mclk_en),
    .rd_data      (rd_data),
    .start        (start),
    .run          (run),
    .act_div      (act_div),
    .dout_valid   (dout_valid),
    .dout_data    (dout_data),
    .busy         (busy),
    .bus_drive_ok (bus_drive_ok)
  );

  a_r1_idle_no_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mclk_en && !dout_valid));
endmodule

// File: tb/sbm_timing_seq_test.sv
`timescale 1ns/1ps
module sbm_timing_seq_test;
  localparam int DW = 16;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [LW-1:0] req_len = '0;
  logic          req_muxed = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          mclk_en, dout_valid, busy, bus_drive_ok;
  logic [DW-1:0] dout_data;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) rd_data <= DW'(cyc);

  sbm_timing_seq #(.DATA_W(DW), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len),
    .req_muxed(req_muxed), .rd_data(rd_data), .mclk_en(mclk_en),
    .dout_valid(dout_valid), .dout_data(dout_data), .busy(busy),
    .bus_drive_ok(bus_drive_ok)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic write_cfg(input int lat, input int dv, input int trn);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {4'h0, 4'(lat), 4'(dv), 4'(trn), 16'h0};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // One transaction; timing values are those the transaction must use.
  task automatic burst(input int dv, input int lat, input int trn, input int len,
                       input bit mux, input bit do_cfg, input bit hold, input bit mid_wr);
    int p, cl, endr, start_cyc;
    string creq;
    p = (dv == 0) ? 2 : dv + 1;
    creq = (dv == 0) ? "R3" : "R2";
    cl = (lat + 2 + len) * p;
    endr = cl + 1 + (mux ? trn + 1 : 0);
    if (do_cfg) write_cfg(lat, dv, trn);
    @(negedge clk);
    req_valid = 1'b1;
    req_len   = LW'(len);
    req_muxed = mux;
    @(negedge clk);
    start_cyc = cyc;
    if (!hold) req_valid = 1'b0;
    for (int r = 0; r <= endr + 2; r++) begin
      bit e_mclk, e_dv, e_busy;
      int q;
      e_mclk = (r <= cl) && (r % p == 0);
      q = (r - 1) / p;
      e_dv = (r >= 1) && ((r - 1) % p == 0) && (q >= lat + 2) && (q <= lat + 2 + len);
      e_busy = (r <= endr);
      chk(mclk_en == e_mclk, creq, "mclk_en", int'(mclk_en), int'(e_mclk));
      chk(dout_valid == e_dv, "R4", "dout_valid", int'(dout_valid), int'(e_dv));
      if (e_dv)
        chk(dout_data == DW'(start_cyc + r - 1), "R5", "dout_data",
            int'(dout_data), int'(DW'(start_cyc + r - 1)));
      chk(busy == e_busy, mux ? "R7" : "R6", "busy", int'(busy), int'(e_busy));
      chk(bus_drive_ok == !e_busy, mux ? "R7" : "R6", "bus_drive_ok",
          int'(bus_drive_ok), int'(!e_busy));
      chk(req_ready == !e_busy, "R9", "req_ready", int'(req_ready), int'(!e_busy));
      if (mid_wr && r == 1) begin cfg_we = 1'b1; cfg_wdata = 32'h0; end
      if (mid_wr && r == 2) cfg_we = 1'b0;
      if (hold && r == cl) req_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (4000000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int divs[4] = '{0, 1, 2, 4};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
    chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
    chk(bus_drive_ok == 1'b1, "R1", "bus_drive_ok", int'(bus_drive_ok), 1);
    chk(mclk_en == 1'b0, "R1", "mclk_en", int'(mclk_en), 0);
    chk(dout_valid == 1'b0, "R1", "dout_valid", int'(dout_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: default fields after reset: divide 15, latency 15, turnaround 15
    burst(15, 15, 15, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R2 R4 R5 R6 R7: sweep
    foreach (divs[i])
      for (int lat = 0; lat <= 2; lat += 2)
        for (int len = 0; len <= 3; len += 3)
          for (int trn = 0; trn <= 3; trn += 3)
            for (int mux = 0; mux <= 1; mux++)
              burst(divs[i], lat, trn, len, 1'(mux), 1'b1, 1'b0, 1'b0);
    // R8: write during burst is deferred, then used by the next one
    burst(3, 1, 2, 2, 1'b1, 1'b1, 1'b0, 1'b1);
    burst(0, 0, 0, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R9: request held high while busy is not accepted
    burst(2, 1, 1, 2, 1'b0, 1'b1, 1'b1, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule